// File: doc/BRIEF.md
# Packet-interface interrupt controller

This block gathers three event strobes from a packet interface: receive done, transmit done and transmit fault. It records each strobe as a sticky pending bit and raises one level-sensitive interrupt line whenever a pending source is also enabled. Software reaches it through a plain register port with an address, a write strobe, write data and combinational read data. There are four 32-bit registers, each holding one bit per source in the same positions.

Enable state is never written as a whole word. One write-only register sets enable bits wherever ones are written, and a second write-only register clears them the same way. A read-only register returns the current enable set. Pending events are read from the status register and acknowledged by writing ones back to it. A second output names the single source that software should service first among the active ones.

Top module: `irq_ctl`

## Requirements
- R1: After reset the enable set, every pending bit, `irq` and `svc_id` are all zero, and every register reads zero.
- R2: A write to offset 0x24 (enable-set) turns on each source whose data bit is 1. Bit 0 is receive done, bit 1 is transmit done and bit 2 is transmit fault. Zero bits leave that source's enable unchanged.
- R3: A write to offset 0x20 (enable-clear) turns off each source whose data bit is 1. Zero bits leave that source's enable unchanged.
- R4: Offset 0x28 returns the enable set in bits 2:0 with zeros above. A write to 0x28 does not change the enable set.
- R5: An event strobe that is high at a clock edge sets its pending bit at that edge, whether or not the source is enabled. Offset 0x2C returns the pending bits in bits 2:0.
- R6: A write to offset 0x2C clears each pending bit whose data bit is 1 and leaves the others unchanged.
- R7: When an event strobe and a write-one clear of the same bit fall on the same edge, the pending bit ends up set.
- R8: `irq` is registered. One edge after some bit is both pending and enabled, `irq` is high. One edge after no bit is both pending and enabled, `irq` is low.
- R9: Reads of 0x20, 0x24 and of unmapped offsets return zero.
- R10: `svc_id` encodes the active source (pending and enabled) with the highest priority: 1 for receive done, then 2 for transmit fault, then 3 for transmit done. It is 0 when no source is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| ev_rx_done | input | 1 | Receive-done event strobe |
| ev_tx_done | input | 1 | Transmit-done event strobe |
| ev_tx_err | input | 1 | Transmit-fault event strobe |
| irq | output | 1 | Registered level interrupt |
| svc_id | output | 2 | Highest-priority active source |

## Verification
An event strobe and a software acknowledge of the same status bit can land on the same edge. The bench provokes this by raising a strobe in the same cycle as a write-one to the status register. In that same write it also clears a second, already pending bit. Afterwards it expects the collided bit to read back set and the other bit to read back clear. The bench also checks that the interrupt line stays high across the collision.

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 32,
  parameter int REG_BASE = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_rx_done,
  input  logic              ev_tx_done,
  input  logic              ev_tx_err,
  output logic              irq,
  output logic [1:0]        svc_id
);
  localparam int NSRC = 3;
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(REG_BASE + 4);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(REG_BASE + 8);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_BASE + 12);

  logic [NSRC-1:0] mask_q, pend_q, ev, act, wbits;

  assign ev    = {ev_tx_err, ev_tx_done, ev_rx_done};
  assign wbits = bus_wdata[NSRC-1:0];
  assign act   = pend_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_SET) mask_q <= mask_q | wbits;
      else if (bus_wr && bus_addr == A_CLR) mask_q <= mask_q & ~wbits;
      if (bus_wr && bus_addr == A_STAT) pend_q <= (pend_q & ~wbits) | ev;
      else pend_q <= pend_q | ev;
      irq <= |act;
    end
  end

  assign svc_id = act[0] ? 2'd1 : act[2] ? 2'd2 : act[1] ? 2'd3 : 2'd0;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_MASK) bus_rdata[NSRC-1:0] = mask_q;
    else if (bus_addr == A_STAT) bus_rdata[NSRC-1:0] = pend_q;
  end
endmodule

module irq_ctl_chk #(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 32,
  parameter int REG_BASE = 'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [2:0]        ev,
  input logic [2:0]        mask,
  input logic [2:0]        pend,
  input logic              irq,
  input logic [1:0]        svc_id
);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(REG_BASE + 4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_BASE + 12);

  a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=> ((mask & $past(bus_wdata[2:0])) == $past(bus_wdata[2:0])));
  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=> ((mask & $past(bus_wdata[2:0])) == 3'b000));
  a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == A_SET || bus_addr == A_CLR)) |=> $stable(mask));
  a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != 3'b000) |=> ((pend & $past(ev)) == $past(ev)));
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT) |=> ((pend & $past(bus_wdata[2:0] & ~ev)) == 3'b000));
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(pend & mask) != 3'b000));

  always @(negedge clk) if (rst_n) begin
    a_r10_rx_first: assert (svc_id != 2'd1 || (pend[0] && mask[0]));
    a_r10_none: assert (svc_id != 2'd0 || (pend & mask) == 3'b000);
  end
endmodule

bind irq_ctl irq_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_BASE(REG_BASE)) chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .ev(ev), .mask(mask_q), .pend(pend_q), .irq(irq), .svc_id(svc_id));

// File: tb/irq_ctl_test.sv
module irq_ctl_test;
  localparam int CLK_NS = 10;
  localparam logic [8:0] A_CLR = 9'h20, A_SET = 9'h24, A_MASK = 9'h28, A_STAT = 9'h2C;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ev_rx_done = 0, ev_tx_done = 0, ev_tx_err = 0, irq;
  logic [1:0] svc_id;
  int checks = 0, fails = 0;

  irq_ctl uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_rx_done(ev_rx_done),
    .ev_tx_done(ev_tx_done), .ev_tx_err(ev_tx_err), .irq(irq), .svc_id(svc_id));

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd_chk(string req, logic [8:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d); check(req, d, exp);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d, logic [2:0] e = 3'b000);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    {ev_tx_err, ev_tx_done, ev_rx_done} = e;
    @(negedge clk);
    bus_wr = 0; {ev_tx_err, ev_tx_done, ev_rx_done} = 3'b000;
  endtask

  task automatic pulse(logic [2:0] e);
    @(negedge clk);
    {ev_tx_err, ev_tx_done, ev_rx_done} = e;
    @(negedge clk);
    {ev_tx_err, ev_tx_done, ev_rx_done} = 3'b000;
  endtask

  task automatic clean();
    wr(A_CLR, 32'h7); wr(A_STAT, 32'h7); @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 irq", irq, 0);
    check("R1 svc_id", svc_id, 0);
    rd_chk("R1 mask", A_MASK, 0);
    rd_chk("R1 status", A_STAT, 0);
  endtask

  task automatic t_enable_disable();
    wr(A_SET, 32'h5);
    rd_chk("R2 set 101", A_MASK, 32'h5);
    wr(A_SET, 32'h2);
    rd_chk("R2 zeros keep", A_MASK, 32'h7);
    wr(A_CLR, 32'h4);
    rd_chk("R3 clear bit2", A_MASK, 32'h3);
    wr(A_CLR, 32'h0);
    rd_chk("R3 zeros keep", A_MASK, 32'h3);
    wr(A_MASK, 32'h4);
    rd_chk("R4 mask write ignored", A_MASK, 32'h3);
    rd_chk("R9 enable-set reads 0", A_SET, 0);
    rd_chk("R9 enable-clear reads 0", A_CLR, 0);
    rd_chk("R9 unmapped reads 0", 9'h30, 0);
    clean();
  endtask

  task automatic t_pending_ack();
    pulse(3'b010);
    rd_chk("R5 masked event pends", A_STAT, 32'h2);
    check("R8 masked no irq", irq, 0);
    pulse(3'b101);
    rd_chk("R5 all pend", A_STAT, 32'h7);
    wr(A_STAT, 32'h2);
    rd_chk("R6 ack bit1 only", A_STAT, 32'h5);
    wr(A_STAT, 32'h0);
    rd_chk("R6 zero ack keeps", A_STAT, 32'h5);
    clean();
  endtask

  task automatic t_irq_timing();
    wr(A_SET, 32'h4);
    @(negedge clk);
    {ev_tx_err, ev_tx_done, ev_rx_done} = 3'b100;
    @(negedge clk);
    ev_tx_err = 0;
    rd_chk("R5 pend set at edge", A_STAT, 32'h4);
    check("R8 irq lags one edge", irq, 0);
    @(negedge clk);
    check("R8 irq high", irq, 1);
    wr(A_STAT, 32'h4);
    check("R8 irq still high after ack edge", irq, 1);
    @(negedge clk);
    check("R8 irq low", irq, 0);
    clean();
  endtask

  task automatic t_collide();
    wr(A_SET, 32'h7);
    pulse(3'b001);
    wr(A_STAT, 32'h3, 3'b010);
    rd_chk("R7 set wins, other cleared", A_STAT, 32'h2);
    check("R7 irq stays", irq, 1);
    clean();
  endtask

  task automatic t_priority();
    wr(A_SET, 32'h7);
    pulse(3'b111);
    check("R10 rx first", svc_id, 1);
    wr(A_STAT, 32'h1);
    check("R10 tx err next", svc_id, 2);
    wr(A_CLR, 32'h4);
    check("R10 masked err skipped", svc_id, 3);
    wr(A_STAT, 32'h2);
    check("R10 none", svc_id, 0);
    clean();
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enable_disable();
    t_pending_ack();
    t_irq_timing();
    t_collide();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule